// File: doc/BRIEF.md
# Two-Level Warp Scheduler

This block decides, once per clock, which warp of a multiprocessor may issue. The 32 warps are divided into a small active pool of 8 slots and a pending pool outside it. Only warps that hold an active slot are considered for issue. Among the ready active warps, the block picks one in round-robin order.

When the chosen warp's next instruction may take a long time, such as a global memory load, the warp still issues that instruction. It then leaves its slot at once. The same output cycle carries a demote event that tells the register hierarchy to flush that warp's cached operands. A demoted warp waits until its completion event arrives. It then joins the tail of the pending queue.

A free slot is refilled from the head of the queue in the cycle after it is freed. The promoted warp can issue from the cycle after that. At reset the active slots hold warps 0 to 7. Warps 8 to 31 are already queued in ascending order, ahead of any warp that completes later.

Top module: `twl_warp_sched`

## Requirements
- R1: After reset all outputs are low. Slot k (k = 0..7) holds warp k, and warps 8..31 are pending in ascending order. The first issue with all warps ready is warp 0.
- R2: A warp outside the active pool never issues, whatever its ready bit.
- R3: The search for a ready active slot starts at the slot after the one that last issued and wraps around. The first ready slot found issues, and its warp id appears on issue_warp one cycle after the inputs.
- R4: While issue_stall is high there is no issue and no demotion, and the round-robin position is kept. Promotion of pending warps still takes place.
- R5: When no active warp is ready, issue_valid and demote_valid are low in the following cycle.
- R6: When the issuing warp has its warp_long bit set, demote_valid is high in the same output cycle as the issue, with demote_warp equal to issue_warp. The warp leaves its slot.
- R7: A slot freed by a demotion is filled in the next cycle from the head of the pending queue, reported on promote_valid/promote_warp. The promoted warp can issue in the cycle after the promotion.
- R8: A demoted warp does not issue again, even with its ready bit high, until done_valid with its id has placed it at the tail of the pending queue.
- R9: Pending warps are promoted strictly in the order they became eligible. When the queue is empty, a free slot stays empty.
- R10: When several slots are free, the lowest-numbered free slot is filled first. This sets the warp's place in the round-robin order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | NUM_WARPS | Per-warp ready-to-issue bit |
| warp_long | input | NUM_WARPS | Per-warp bit: next instruction may have long latency |
| issue_stall | input | 1 | Blocks issue for this cycle |
| done_valid | input | 1 | A long-latency operation has completed |
| done_warp | input | log2(NUM_WARPS) | Warp whose operation completed |
| issue_valid | output | 1 | A warp issues (registered) |
| issue_warp | output | log2(NUM_WARPS) | Id of the issuing warp |
| demote_valid | output | 1 | Issuing warp leaves the active pool; flush its register cache |
| demote_warp | output | log2(NUM_WARPS) | Id of the demoted warp |
| promote_valid | output | 1 | A pending warp entered a free slot |
| promote_warp | output | log2(NUM_WARPS) | Id of the promoted warp |

## Verification
With every warp ready and no long-latency bits, the bench checks that issue rotates through the active slots. With only pending warps ready, it checks that they stay silent. A single active ready warp among many ready pending warps separates pool-limited issue from plain ready masking. A run with every warp's long bit set drains the pending queue. It shows whether promotions follow queue order and whether they come one cycle after each demotion. Completion events given in a non-numeric order (5, 2, 30) after full drainage separate FIFO eligibility from lowest-id selection. They also show that demoted warps stay silent until their completion arrives.

// File: rtl/twl_pkg.sv
`timescale 1ns/1ps
package twl_pkg;
  localparam int unsigned WARPS_DEFAULT = 32;
  localparam int unsigned SLOTS_DEFAULT = 8;

  // next index on a ring of the given size
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned size);
    return (idx + 1 == size) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/twl_rr_pick.sv
`timescale 1ns/1ps
module twl_rr_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  // scan from farthest to nearest so the nearest request after 'last' wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N; k >= 1; k--) begin
      int unsigned s;
      s = (int'(last) + k) % N;
      if (req[s]) begin
        found = 1'b1;
        idx   = IW'(s);
      end
    end
  end

  p_pick_is_requested_r3: assert property (@(posedge clk) disable iff (rst)
    found |-> req[idx]);
  p_any_req_found_r3: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> found);
endmodule

// File: rtl/twl_pend_fifo.sv
`timescale 1ns/1ps
module twl_pend_fifo #(
  parameter int unsigned NUM_WARPS  = 32,
  parameter int unsigned FRESH_BASE = 8,
  localparam int unsigned WW = $clog2(NUM_WARPS),
  localparam int unsigned CW = $clog2(NUM_WARPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [WW-1:0] push_warp,
  input  logic          pop,
  output logic          nonempty,
  output logic [WW-1:0] head_warp
);
  logic [WW-1:0] mem [NUM_WARPS];
  logic [WW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] stored;
  logic [CW-1:0] fresh_next;
  logic          fresh_left;
  logic          pop_mem;

  // warps never activated since reset are eligible before any completed warp
  assign fresh_left = (fresh_next != CW'(NUM_WARPS));
  assign pop_mem    = pop && !fresh_left;
  assign nonempty   = fresh_left || (stored != '0);
  assign head_warp  = fresh_left ? fresh_next[WW-1:0] : mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_warp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      stored     <= '0;
      fresh_next <= CW'(FRESH_BASE);
    end else begin
      if (push)
        wr_ptr <= WW'(twl_pkg::ring_next(int'(wr_ptr), NUM_WARPS));
      if (pop_mem)
        rd_ptr <= WW'(twl_pkg::ring_next(int'(rd_ptr), NUM_WARPS));
      if (pop && fresh_left)
        fresh_next <= fresh_next + 1'b1;
      case ({push, pop_mem})
        2'b10:   stored <= stored + 1'b1;
        2'b01:   stored <= stored - 1'b1;
        default: stored <= stored;
      endcase
    end
  end

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !pop_mem) |-> (stored != CW'(NUM_WARPS)));
endmodule

// File: rtl/twl_warp_sched.sv
`timescale 1ns/1ps
module twl_warp_sched #(
  parameter int unsigned NUM_WARPS    = twl_pkg::WARPS_DEFAULT,
  parameter int unsigned ACTIVE_SLOTS = twl_pkg::SLOTS_DEFAULT,
  localparam int unsigned WW = $clog2(NUM_WARPS),
  localparam int unsigned SW = $clog2(ACTIVE_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic [NUM_WARPS-1:0] warp_long,
  input  logic                 issue_stall,
  input  logic                 done_valid,
  input  logic [WW-1:0]        done_warp,
  output logic                 issue_valid,
  output logic [WW-1:0]        issue_warp,
  output logic                 demote_valid,
  output logic [WW-1:0]        demote_warp,
  output logic                 promote_valid,
  output logic [WW-1:0]        promote_warp
);
  logic [ACTIVE_SLOTS-1:0] slot_v;
  logic [WW-1:0]           slot_w [ACTIVE_SLOTS];
  logic [SW-1:0]           last_q;

  logic [ACTIVE_SLOTS-1:0] slot_req;
  logic                    pick_found;
  logic [SW-1:0]           pick_idx;
  logic [WW-1:0]           pick_warp;
  logic                    pick_long;
  logic                    free_found;
  logic [SW-1:0]           free_idx;
  logic                    q_nonempty;
  logic [WW-1:0]           q_head;
  logic                    do_promote;

  // a slot requests issue when it holds a ready warp and issue is not stalled
  always_comb begin
    for (int s = 0; s < ACTIVE_SLOTS; s++)
      slot_req[s] = slot_v[s] && warp_ready[slot_w[s]] && !issue_stall;
  end

  twl_rr_pick #(.N(ACTIVE_SLOTS)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (slot_req),
    .last  (last_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign pick_warp = slot_w[pick_idx];
  assign pick_long = pick_found && warp_long[pick_warp];

  // lowest-numbered empty slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int s = ACTIVE_SLOTS - 1; s >= 0; s--) begin
      if (!slot_v[s]) begin
        free_found = 1'b1;
        free_idx   = SW'(s);
      end
    end
  end

  assign do_promote = free_found && q_nonempty;

  twl_pend_fifo #(.NUM_WARPS(NUM_WARPS), .FRESH_BASE(ACTIVE_SLOTS)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .push      (done_valid),
    .push_warp (done_warp),
    .pop       (do_promote),
    .nonempty  (q_nonempty),
    .head_warp (q_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v        <= '1;
      last_q        <= SW'(ACTIVE_SLOTS - 1);
      issue_valid   <= 1'b0;
      issue_warp    <= '0;
      demote_valid  <= 1'b0;
      demote_warp   <= '0;
      promote_valid <= 1'b0;
      promote_warp  <= '0;
      for (int s = 0; s < ACTIVE_SLOTS; s++)
        slot_w[s] <= WW'(s);
    end else begin
      issue_valid   <= pick_found;
      demote_valid  <= pick_long;
      promote_valid <= do_promote;
      if (pick_found) begin
        issue_warp <= pick_warp;
        last_q     <= pick_idx;
      end
      if (pick_long) begin
        demote_warp      <= pick_warp;
        slot_v[pick_idx] <= 1'b0;
      end
      if (do_promote) begin
        promote_warp     <= q_head;
        slot_v[free_idx] <= 1'b1;
        slot_w[free_idx] <= q_head;
      end
    end
  end

  p_demote_flush_r6: assert property (@(posedge clk) disable iff (rst)
    demote_valid |-> (issue_valid && demote_warp == issue_warp));
  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    issue_stall |=> (!issue_valid && !demote_valid));
  p_promote_next_r7: assert property (@(posedge clk) disable iff (rst)
    do_promote |=> (promote_valid && promote_warp == $past(q_head)));
  p_promote_not_issuer_r2: assert property (@(posedge clk) disable iff (rst)
    (promote_valid && issue_valid) |-> (promote_warp != issue_warp));
endmodule

// File: tb/twl_warp_sched_test.sv
`timescale 1ns/1ps
module twl_warp_sched_test;
  localparam int N = 32;
  localparam int S = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst = 1'b1;
  logic [N-1:0] warp_ready = '0, warp_long = '0;
  logic         issue_stall = 1'b0, done_valid = 1'b0;
  logic [4:0]   done_warp = '0;
  logic         issue_valid, demote_valid, promote_valid;
  logic [4:0]   issue_warp, demote_warp, promote_warp;

  twl_warp_sched uut (
    .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_long(warp_long),
    .issue_stall(issue_stall), .done_valid(done_valid), .done_warp(done_warp),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .demote_valid(demote_valid), .demote_warp(demote_warp),
    .promote_valid(promote_valid), .promote_warp(promote_warp)
  );

  typedef struct {
    int due; bit iv; int iw; bit dv; int dw; bit pv; int pw;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];
  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;

  // reference model built from the requirements
  bit mv[S];
  int mw[S];
  int mlast;
  int mq[$];

  always @(posedge clk) cyc++;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic step(input logic [N-1:0] rdy, input logic [N-1:0] lng,
                      input bit stl, input bit dv, input int dw, input string tag);
    exp_t e;
    int is, free;
    e.due = cyc + 1; e.iv = 0; e.iw = 0; e.dv = 0; e.dw = 0; e.pv = 0; e.pw = 0;
    is = 0; free = -1;
    if (!stl) begin
      for (int k = 1; k <= S; k++) begin
        int s;
        s = (mlast + k) % S;
        if (mv[s] && rdy[mw[s]]) begin
          e.iv = 1; e.iw = mw[s]; is = s;
          break;
        end
      end
    end
    for (int s = 0; s < S; s++) begin
      if (!mv[s]) begin free = s; break; end
    end
    e.dv = e.iv && lng[e.iw];
    e.dw = e.iw;
    e.pv = (free >= 0) && (mq.size() > 0);
    if (e.iv) mlast = is;
    if (e.dv) mv[is] = 0;
    if (e.pv) begin
      e.pw = mq.pop_front();
      mv[free] = 1; mw[free] = e.pw;
    end
    if (dv) mq.push_back(dw);
    expq.push_back(e); tagq.push_back(tag);
    warp_ready = rdy; warp_long = lng; issue_stall = stl;
    done_valid = dv; done_warp = 5'(dw);
    @(negedge clk);
  endtask

  // monitor: compare each expected item in the cycle its result appears
  always @(negedge clk) begin
    if (expq.size() > 0 && expq[0].due == cyc) begin
      exp_t e;
      string t;
      bit ok;
      e = expq.pop_front(); t = tagq.pop_front();
      compared++;
      ok = (issue_valid == e.iv) && (!e.iv || issue_warp == 5'(e.iw)) &&
           (demote_valid == e.dv) && (!e.dv || demote_warp == 5'(e.dw)) &&
           (promote_valid == e.pv) && (!e.pv || promote_warp == 5'(e.pw));
      if (!ok) begin
        mismatched++;
        $display("FAIL %s cyc %0d: got iv=%0d iw=%0d dv=%0d dw=%0d pv=%0d pw=%0d, exp iv=%0d iw=%0d dv=%0d dw=%0d pv=%0d pw=%0d",
                 t, cyc, issue_valid, issue_warp, demote_valid, demote_warp,
                 promote_valid, promote_warp, e.iv, e.iw, e.dv, e.dw, e.pv, e.pw);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R1 watchdog: got no completion, exp completion within limit");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] all_w;
    all_w = '1;
    for (int s = 0; s < S; s++) begin mv[s] = 1; mw[s] = s; end
    mlast = S - 1;
    for (int w = S; w < N; w++) mq.push_back(w);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    compared++;
    if (issue_valid || demote_valid || promote_valid) begin
      mismatched++;
      $display("FAIL R1 reset: got iv=%0d dv=%0d pv=%0d, exp 0 0 0",
               issue_valid, demote_valid, promote_valid);
    end

    step(all_w, '0, 0, 0, 0, "R1");                  // first issue is warp 0
    repeat (9) step(all_w, '0, 0, 0, 0, "R3");       // rotation over slots
    step(all_w, '0, 1, 0, 0, "R4");                  // stall
    step(all_w, all_w, 1, 0, 0, "R4");               // stall blocks demotion too
    repeat (3) step(32'hFFFF_FF08, '0, 0, 0, 0, "R2"); // only warp 3 is active and ready
    step(32'hFFFF_FF00, '0, 0, 0, 0, "R5");          // only pending warps ready
    step('0, '0, 0, 0, 0, "R5");
    step(all_w, all_w, 0, 0, 0, "R6");               // one long issue -> demote
    repeat (3) step(all_w, '0, 0, 0, 0, "R7");       // refill and issue of new warp
    step(all_w, 32'h0000_0300, 0, 0, 0, "R10");
    repeat (6) step(all_w, '0, 0, 0, 0, "R10");
    repeat (45) step(all_w, all_w, 0, 0, 0, "R9");   // drain all warps
    repeat (2) step(all_w, '0, 0, 0, 0, "R8");       // demoted warps stay silent
    step(all_w, '0, 0, 1, 5, "R8");
    step(all_w, '0, 0, 1, 2, "R9");
    step(all_w, '0, 0, 1, 30, "R9");
    repeat (4) step(all_w, '0, 0, 0, 0, "R9");
    step(all_w, '0, 1, 1, 9, "R4");                  // completion queued during stall
    repeat (3) step(all_w, '0, 0, 0, 0, "R7");

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule